// File: doc/BRIEF.md
# ACPI Power Management Event Controller

This block holds the fixed power management register group of a system controller. A free-running timer advances on an external tick strobe (3.579545 MHz in the system) and flags an event every time its top bit flips. A sticky status word gathers timer, global, RTC, power-button and resume events. An enable word selects which of them drive the level-sensitive SCI line. A control word holds the ACPI-mode bit and a suspend command, and a byte-wide APM command port switches ACPI mode on and off.

Software reaches the registers through a simple synchronous word bus: writes take effect at the clock edge and reads are combinational. A write to the control register with the suspend-enable bit set carries out the selected suspend type. Type 0 emits a one-cycle power-off request. Type 1 is looped back as a resume: it sets the resume and power-button status bits and emits a one-cycle reset request.

Top module: `pm_event_ctrl`

## Requirements
- R1: The timer is TMR_W bits wide (default 24), resets to 0 and advances by one, modulo 2^TMR_W, on each cycle where `tick_i` is high. Its low 16 bits read at offset 0x8 and its upper bits, zero-extended, at offset 0xA. Writes to either offset are ignored.
- R2: Status bit 0 (timer overflow) sets on each tick that toggles the timer's most significant bit, i.e. whenever the count crosses a multiple of 2^(TMR_W-1).
- R3: The status word is at offset 0x0 and the enable word at 0x2. Both use the same bit layout: bit 0 timer, bit 5 global, bit 8 power button, bit 10 RTC. Status bit 15 is resume. A one-cycle pulse on `gbl_evt_i` sets status bit 5 and one on `rtc_evt_i` sets status bit 10. Status bits other than 0, 5, 8, 10 and 15 always read 0, and the enable word reads back as written.
- R4: A pulse on `pwrbtn_i` sets status bit 8 only while enable bit 8 is 1.
- R5: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear wins.
- R6: `sci_o` is high exactly while some bit among 0, 5, 8 and 10 is 1 in both status and enable.
- R7: The control word at offset 0x4 stores bit 0 (ACPI mode) and bits 12:10 (suspend type) as written. Bit 13 (suspend enable) is never stored and reads as 0.
- R8: A control write with bit 13 set and suspend type 0 drives `poweroff_req_o` high for exactly the one cycle after the write edge.
- R9: A control write with bit 13 set and suspend type 1 sets status bits 15 and 8 and drives `reset_req_o` high for one cycle. Any other type, or bit 13 clear, produces no pulse and no status change.
- R10: An APM byte write of 0xF1 sets control bit 0 and 0xF0 clears it. Any value written is stored and read back on `apm_rdata_o`, and other values leave control unchanged.
- R11: After reset, status, enable, control, APM byte and timer are all 0, and `sci_o`, `poweroff_req_o` and `reset_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timer advance strobe |
| wr_i | input | 1 | Register word write strobe |
| addr_i | input | 4 | Register byte offset (even) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for `addr_i` |
| apm_wr_i | input | 1 | APM command byte write strobe |
| apm_wdata_i | input | 8 | APM command byte |
| apm_rdata_o | output | 8 | Last APM command byte written |
| gbl_evt_i | input | 1 | Global event pulse |
| rtc_evt_i | input | 1 | RTC alarm event pulse |
| pwrbtn_i | input | 1 | Power-button event pulse |
| sci_o | output | 1 | Level-sensitive system control interrupt |
| poweroff_req_o | output | 1 | One-cycle power-off request |
| reset_req_o | output | 1 | One-cycle reset (resume) request |

## Verification
The hardest state to reach from the ports is one where the timer-overflow bit sits alongside an arbitrary subset of the other sources, because that bit only sets when the counter's top bit flips. The bench builds the design with a 10-bit timer, so 512 ticks always cross exactly one flip point. It first steps the timer tick by tick through more than a full wrap, checking each count and each flag. Then, for every one of the 16 status subsets, it sets all sources, clears the complement by write-one-to-clear, and sweeps all 16 enable masks against the SCI line.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned OFS_W = 4;

  localparam int unsigned B_TMR   = 0;
  localparam int unsigned B_GBL   = 5;
  localparam int unsigned B_PWR   = 8;
  localparam int unsigned B_RTC   = 10;
  localparam int unsigned B_RSM   = 15;
  localparam int unsigned B_ACPI  = 0;
  localparam int unsigned B_SUSGO = 13;
  localparam int unsigned SUS_LO  = 10;
  localparam int unsigned SUS_W   = 3;

  localparam logic [REG_W-1:0] SCI_SRC  = 16'h0521;
  localparam logic [REG_W-1:0] STS_IMPL = 16'h8521;

  localparam logic [OFS_W-1:0] OFS_STS = 4'h0;
  localparam logic [OFS_W-1:0] OFS_EN  = 4'h2;
  localparam logic [OFS_W-1:0] OFS_CTL = 4'h4;
  localparam logic [OFS_W-1:0] OFS_TLO = 4'h8;
  localparam logic [OFS_W-1:0] OFS_THI = 4'hA;

  localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
  localparam logic [7:0] APM_ACPI_OFF = 8'hF0;

  typedef enum logic [SUS_W-1:0] {
    SUS_POWEROFF = 3'd0,
    SUS_RESUME   = 3'd1
  } sus_kind_e;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             msb_flip_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign msb_flip_o = tick_i & (&cnt_q[TMR_W-2:0]);

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_o == TMR_W'($past(cnt_o) + TMR_W'(1)));
  assert_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o));
  assert_flip_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msb_flip_o |=> cnt_o[TMR_W-1] != $past(cnt_o[TMR_W-1]));
endmodule

// File: rtl/pm_status.sv
module pm_status
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr_i,
  input  logic             en_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             tmr_evt_i,
  input  logic             gbl_evt_i,
  input  logic             rtc_evt_i,
  input  logic             pwrbtn_i,
  input  logic             resume_set_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o,
  output logic             sci_o
);
  logic [REG_W-1:0] sts_q, sts_d, en_q, en_d, set_v;

  always_comb begin
    set_v        = '0;
    set_v[B_TMR] = tmr_evt_i;
    set_v[B_GBL] = gbl_evt_i;
    set_v[B_RTC] = rtc_evt_i;
    set_v[B_PWR] = (pwrbtn_i & en_q[B_PWR]) | resume_set_i;
    set_v[B_RSM] = resume_set_i;
  end

  always_comb begin
    sts_d = sts_q;
    if (sts_wr_i) sts_d = sts_d & ~wdata_i;
    sts_d = (sts_d | set_v) & STS_IMPL;
  end

  always_comb begin
    en_d = en_q;
    if (en_wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign sci_o = |(sts_q & en_q & SCI_SRC);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr_i && wdata_i[B_RTC] && !rtc_evt_i |=> !sts_o[B_RTC]);
  assert_pwrbtn_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_i && !en_o[B_PWR] && !sts_o[B_PWR] && !resume_set_i |=> !sts_o[B_PWR]);
  assert_sci_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o && !sts_wr_i && !en_wr_i |=> sci_o);
endmodule

// File: rtl/pm_control.sv
module pm_control
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             apm_wr_i,
  input  logic [7:0]       apm_data_i,
  output logic [REG_W-1:0] ctl_o,
  output logic [7:0]       apm_o,
  output logic             resume_set_o,
  output logic             poweroff_o,
  output logic             reset_req_o
);
  logic [REG_W-1:0] ctl_q, ctl_d;
  logic [7:0]       apm_q, apm_d;
  logic             off_q, rst_q;
  logic             sus_go;
  sus_kind_e        sus_kind;

  assign sus_go       = ctl_wr_i & wdata_i[B_SUSGO];
  assign sus_kind     = sus_kind_e'(wdata_i[SUS_LO +: SUS_W]);
  assign resume_set_o = sus_go && (sus_kind == SUS_RESUME);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr_i) begin
      ctl_d          = wdata_i;
      ctl_d[B_SUSGO] = 1'b0;
    end
    if (apm_wr_i && apm_data_i == APM_ACPI_ON)  ctl_d[B_ACPI] = 1'b1;
    if (apm_wr_i && apm_data_i == APM_ACPI_OFF) ctl_d[B_ACPI] = 1'b0;
    apm_d = apm_q;
    if (apm_wr_i) apm_d = apm_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      apm_q <= '0;
      off_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      apm_q <= apm_d;
      off_q <= sus_go && (sus_kind == SUS_POWEROFF);
      rst_q <= resume_set_o;
    end
  end

  assign ctl_o       = ctl_q;
  assign apm_o       = apm_q;
  assign poweroff_o  = off_q;
  assign reset_req_o = rst_q;

  assert_poweroff_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_o |-> $past(ctl_wr_i && wdata_i[B_SUSGO] && wdata_i[SUS_LO +: SUS_W] == 3'd0));
  assert_reset_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(ctl_wr_i && wdata_i[B_SUSGO] && wdata_i[SUS_LO +: SUS_W] == 3'd1));
  assert_apm_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    apm_wr_i && apm_data_i == APM_ACPI_ON |=> ctl_o[B_ACPI]);
  assert_apm_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    apm_wr_i && apm_data_i == APM_ACPI_OFF |=> !ctl_o[B_ACPI]);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             apm_wr_i,
  input  logic [7:0]       apm_wdata_i,
  output logic [7:0]       apm_rdata_o,
  input  logic             gbl_evt_i,
  input  logic             rtc_evt_i,
  input  logic             pwrbtn_i,
  output logic             sci_o,
  output logic             poweroff_req_o,
  output logic             reset_req_o
);
  localparam int unsigned EXT_W = 2 * REG_W;

  logic [TMR_W-1:0] tmr_cnt;
  logic [EXT_W-1:0] tmr_ext;
  logic             tmr_flip, resume_set;
  logic [REG_W-1:0] sts, en, ctl;
  logic             sts_wr, en_wr, ctl_wr;

  assign sts_wr  = wr_i && (addr_i == OFS_STS);
  assign en_wr   = wr_i && (addr_i == OFS_EN);
  assign ctl_wr  = wr_i && (addr_i == OFS_CTL);
  assign tmr_ext = EXT_W'(tmr_cnt);

  pm_timer #(.TMR_W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cnt_o(tmr_cnt), .msb_flip_o(tmr_flip)
  );

  pm_status status_i (
    .clk(clk), .rst_n(rst_n), .sts_wr_i(sts_wr), .en_wr_i(en_wr),
    .wdata_i(wdata_i), .tmr_evt_i(tmr_flip), .gbl_evt_i(gbl_evt_i),
    .rtc_evt_i(rtc_evt_i), .pwrbtn_i(pwrbtn_i), .resume_set_i(resume_set),
    .sts_o(sts), .en_o(en), .sci_o(sci_o)
  );

  pm_control control_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .wdata_i(wdata_i),
    .apm_wr_i(apm_wr_i), .apm_data_i(apm_wdata_i), .ctl_o(ctl),
    .apm_o(apm_rdata_o), .resume_set_o(resume_set),
    .poweroff_o(poweroff_req_o), .reset_req_o(reset_req_o)
  );

  always_comb begin
    unique case (addr_i)
      OFS_STS: rdata_o = sts;
      OFS_EN:  rdata_o = en;
      OFS_CTL: rdata_o = ctl;
      OFS_TLO: rdata_o = tmr_ext[REG_W-1:0];
      OFS_THI: rdata_o = tmr_ext[EXT_W-1:REG_W];
      default: rdata_o = '0;
    endcase
  end

  assert_onehot_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({poweroff_req_o, reset_req_o}));
  assert_resume_sts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> sts[B_RSM] && sts[B_PWR]);
endmodule

// File: tb/pm_event_ctrl_tb_top.sv
module pm_event_ctrl_tb_top;
  localparam int unsigned TW   = 10;
  localparam int unsigned TMOD = 1 << TW;
  localparam int unsigned HALF = 1 << (TW - 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr = 1'b0, apm_wr = 1'b0;
  logic        gbl = 1'b0, rtc = 1'b0, pwr = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [7:0]  apm_d = 8'h0;
  logic [15:0] rdata;
  logic [7:0]  apm_q;
  logic        sci, poff, rreq;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  pm_event_ctrl #(.TMR_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .apm_wr_i(apm_wr), .apm_wdata_i(apm_d),
    .apm_rdata_o(apm_q), .gbl_evt_i(gbl), .rtc_evt_i(rtc), .pwrbtn_i(pwr),
    .sci_o(sci), .poweroff_req_o(poff), .reset_req_o(rreq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, 32'(v), 32'(exp));
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic apm(input logic [7:0] d);
    apm_d = d; apm_wr = 1'b1;
    @(negedge clk);
    apm_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_evt(input int which);
    if (which == 0) gbl = 1'b1;
    if (which == 1) rtc = 1'b1;
    if (which == 2) pwr = 1'b1;
    @(negedge clk);
    gbl = 1'b0; rtc = 1'b0; pwr = 1'b0;
  endtask

  function automatic logic [15:0] spread(input logic [3:0] m);
    logic [15:0] r = '0;
    r[0] = m[0]; r[5] = m[1]; r[8] = m[2]; r[10] = m[3];
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned texp;
    logic        oexp;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk_rd("R11 sts", 4'h0, 16'h0);
    chk_rd("R11 en", 4'h2, 16'h0);
    chk_rd("R11 ctl", 4'h4, 16'h0);
    chk_rd("R11 tmr", 4'h8, 16'h0);
    chk("R11 apm", 32'(apm_q), 0);
    chk("R11 outs", {29'd0, sci, poff, rreq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: tick-by-tick sweep past a full wrap
    texp = 0; oexp = 1'b0;
    for (int i = 1; i <= 1100; i++) begin
      logic [15:0] v;
      ticks(1);
      texp = (texp + 1) % TMOD;
      if (texp % HALF == 0) oexp = 1'b1;
      chk_rd("R1 timer count", 4'h8, 16'(texp));
      rd(4'h0, v);
      chk("R2 overflow flag", 32'(v[0]), 32'(oexp));
      if (i == 600) begin
        wr16(4'h0, 16'h0001);
        oexp = 1'b0;
        chk_rd("R5 clear overflow", 4'h0, 16'h0);
      end
    end
    chk_rd("R1 timer high word", 4'hA, 16'h0);
    wr16(4'h8, 16'hFFFF);
    wr16(4'hA, 16'hFFFF);
    chk_rd("R1 timer write ignored", 4'h8, 16'(texp));
    wr16(4'h0, 16'hFFFF);

    // R3/R5/R6: every status subset against every enable mask
    for (int s = 0; s < 16; s++) begin
      wr16(4'h2, 16'h0521);
      ticks(HALF);
      pulse_evt(0); pulse_evt(1); pulse_evt(2);
      chk_rd("R3 all sources set", 4'h0, 16'h0521);
      wr16(4'h0, spread(~4'(s)) | 16'h7ADE);
      chk_rd("R5 partial clear", 4'h0, spread(4'(s)));
      for (int e = 0; e < 16; e++) begin
        wr16(4'h2, spread(4'(e)) | 16'h1002);
        chk("R6 sci level", 32'(sci), 32'(|(4'(s) & 4'(e))));
      end
      chk_rd("R3 enable readback", 4'h2, 16'h1002 | spread(4'hF));
      wr16(4'h0, 16'hFFFF);
    end

    // R4: power button gating
    wr16(4'h2, 16'h0000);
    pulse_evt(2);
    chk_rd("R4 pwrbtn masked", 4'h0, 16'h0);
    chk("R4 sci off", 32'(sci), 0);
    wr16(4'h2, 16'h0100);
    pulse_evt(2);
    chk_rd("R4 pwrbtn enabled", 4'h0, 16'h0100);
    chk("R6 sci on pwrbtn", 32'(sci), 1);
    wr16(4'h0, 16'h0100);
    chk("R5 sci drops on clear", 32'(sci), 0);

    // R9: resume loop-back
    wr16(4'h4, 16'h2401);
    chk("R9 reset pulse", {30'd0, rreq, poff}, 32'h2);
    chk_rd("R9 status resume+pwrbtn", 4'h0, 16'h8100);
    chk_rd("R7 susgo not stored", 4'h4, 16'h0401);
    @(negedge clk);
    chk("R9 reset pulse ends", 32'(rreq), 0);
    wr16(4'h0, 16'hFFFF);

    // R8: power-off
    wr16(4'h4, 16'h2000);
    chk("R8 poweroff pulse", {30'd0, rreq, poff}, 32'h1);
    chk_rd("R7 ctl after poweroff", 4'h4, 16'h0000);
    @(negedge clk);
    chk("R8 poweroff pulse ends", 32'(poff), 0);

    // R9: no action without suspend-enable or with other type
    wr16(4'h4, 16'h0400);
    chk("R9 no go no pulse", {30'd0, rreq, poff}, 0);
    chk_rd("R9 no go no status", 4'h0, 16'h0);
    wr16(4'h4, 16'h2800);
    chk("R9 type2 no pulse", {30'd0, rreq, poff}, 0);
    chk_rd("R7 type field", 4'h4, 16'h0800);

    // R10: APM command port
    apm(8'hF1);
    chk_rd("R10 acpi on", 4'h4, 16'h0801);
    chk("R10 apm readback F1", 32'(apm_q), 32'hF1);
    apm(8'h55);
    chk_rd("R10 other value no effect", 4'h4, 16'h0801);
    chk("R10 apm readback 55", 32'(apm_q), 32'h55);
    apm(8'hF0);
    chk_rd("R10 acpi off", 4'h4, 16'h0800);
    chk("R10 apm readback F0", 32'(apm_q), 32'hF0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule